// File: doc/BRIEF.md
# Time-of-Day Alarm Matcher with Repeat Modes

The block watches a calendar clock and decides, once per clock update, whether the programmed alarm time has come. On every one-second update strobe it compares the current month, day of month, hours, minutes and seconds, all held as two-digit BCD bytes, against the matching alarm bytes. A five-bit repeat code chooses how many of those fields take part, from none up to all five. When the comparison succeeds, an alarm flag is set and an interrupt may be raised.

The interrupt depends on an alarm-interrupt enable. While the system runs from its backup supply, a second enable must also be set. Software clears the two outputs in two steps with reads of the flags register. The first read drops the interrupt and leaves the flag. A later read clears the flag. The clock counters, the register file and the bus decoding are outside the block. Its inputs are the register contents and a read strobe.

Top module: `alm_matcher`

## Requirements
- R1: After reset both `alarm_flag_o` and `irq_o` are 0.
- R2: Repeat code 5'b11111 (bit 4 first) makes every update strobe an alarm event, whatever the field values.
- R3: Repeat code 5'b11110 compares only the seconds field; a seconds mismatch blocks the event and the other fields are ignored.
- R4: Repeat code 5'b11100 compares seconds and minutes only.
- R5: Repeat code 5'b11000 compares seconds, minutes and hours only.
- R6: Repeat code 5'b10000 compares seconds, minutes, hours and day of month; the month field is ignored.
- R7: Repeat code 5'b00000 compares all five fields, giving a yearly alarm.
- R8: Every repeat code other than the six listed in R2 to R7 behaves as 5'b11111.
- R9: An event happens only in a cycle where `tick_i` is 1. Matching fields without a strobe do not change the outputs. Outputs take the result at the first rising clock edge that samples the strobe (with `PIPE_CMP` = 0).
- R10: Outside backup mode, an event sets `alarm_flag_o`, and it also sets `irq_o` if `afe_i` is 1. With `afe_i` at 0, only the flag is set.
- R11: With `bkup_i` = 1, an event sets `irq_o` only when both `afe_i` and `abe_i` are 1. The flag is always set.
- R12: A `flags_rd_i` pulse while `irq_o` is 1 clears `irq_o` and keeps the flag. A pulse while `irq_o` is 0 clears `alarm_flag_o`.
- R13: When an event and a flags read fall in the same cycle, the event wins. The flag ends at 1, and `irq_o` is 1 if it was already 1 or if the enable condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle clock update strobe |
| cur_sec_i | input | FW | Current seconds, BCD |
| cur_min_i | input | FW | Current minutes, BCD |
| cur_hr_i | input | FW | Current hours, BCD |
| cur_date_i | input | FW | Current day of month, BCD |
| cur_mon_i | input | FW | Current month, BCD |
| alm_sec_i | input | FW | Alarm seconds, BCD |
| alm_min_i | input | FW | Alarm minutes, BCD |
| alm_hr_i | input | FW | Alarm hours, BCD |
| alm_date_i | input | FW | Alarm day of month, BCD |
| alm_mon_i | input | FW | Alarm month, BCD |
| rpt_i | input | 5 | Repeat code, bit 4 first |
| afe_i | input | 1 | Alarm interrupt enable |
| abe_i | input | 1 | Interrupt enable in backup mode |
| bkup_i | input | 1 | Running from backup supply |
| flags_rd_i | input | 1 | Flags register read strobe |
| alarm_flag_o | output | 1 | Alarm flag |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
A new alarm event and a flags-register read can land in the same cycle. The read would release the interrupt or clear the flag, and the event would set them. The bench provokes this in directed steps. In one, the interrupt is already pending. In the other, only the flag is set. The random phase also raises the strobe and the read together at random. After each such cycle the bench expects the flag at 1 and the interrupt pending whenever it was pending before or the enables allow it. Any sign that the read took effect instead counts as a failure.

// File: rtl/alm_pkg.sv
package alm_pkg;
   localparam int NF     = 5;
   localparam int F_SEC  = 0;
   localparam int F_MIN  = 1;
   localparam int F_HR   = 2;
   localparam int F_DATE = 3;
   localparam int F_MON  = 4;
   typedef logic [NF-1:0] fmask_t;
endpackage

// File: rtl/alm_mask_dec.sv
// Turns the repeat code into a mask of compared fields (bit i = field i).
// Legal codes are ones above zeros; z trailing zeros compare the z lowest fields.
module alm_mask_dec
   import alm_pkg::*;
#(
   parameter int RW = NF
) (
   input  logic [RW-1:0] code_i,
   output fmask_t        mask_o
);
   if (RW != NF) begin : g_bad_rw
      $error("alm_mask_dec: code width must equal field count");
   end

   always_comb begin
      mask_o = '0;
      for (int z = 0; z <= NF; z++) begin
         if (code_i == ~RW'((1 << z) - 1)) mask_o = NF'((1 << z) - 1);
      end
   end

   // R8: any mask produced is a run of low ones
   always_comb begin
      p_mask_contig_r8: assert (((mask_o + 1'b1) & mask_o) == '0);
   end
endmodule

// File: rtl/alm_field_cmp.sv
module alm_field_cmp
   import alm_pkg::*;
#(
   parameter int FW       = 8,
   parameter int PIPE_CMP = 0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   tick_i,
   input  logic [NF-1:0][FW-1:0]  cur_i,
   input  logic [NF-1:0][FW-1:0]  alm_i,
   input  fmask_t                 mask_i,
   output logic                   ev_o
);
   fmask_t eq;
   logic   hit;

   for (genvar i = 0; i < NF; i++) begin : g_eq
      assign eq[i] = (cur_i[i] == alm_i[i]);
   end

   assign hit = &(eq | ~mask_i);

   if (PIPE_CMP != 0) begin : g_pipe
      logic ev_q;
      always_ff @(posedge clk) begin
         if (!rst_n) ev_q <= 1'b0;
         else        ev_q <= tick_i & hit;
      end
      assign ev_o = ev_q;

      p_free_mask_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (tick_i && mask_i == '0) |=> ev_o);
   end else begin : g_comb
      assign ev_o = tick_i & hit;

      p_free_mask_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (tick_i && mask_i == '0) |-> ev_o);
   end
endmodule

// File: rtl/alm_irq_ctrl.sv
module alm_irq_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic ev_i,
   input  logic afe_i,
   input  logic abe_i,
   input  logic bkup_i,
   input  logic rd_i,
   output logic flag_o,
   output logic irq_o
);
   logic gate;
   assign gate = afe_i & (~bkup_i | abe_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_o <= 1'b0;
         irq_o  <= 1'b0;
      end else if (ev_i) begin
         flag_o <= 1'b1;
         irq_o  <= irq_o | gate;
      end else if (rd_i) begin
         if (irq_o) irq_o  <= 1'b0;
         else       flag_o <= 1'b0;
      end
   end

   p_irq_implies_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> flag_o);
   p_flag_only_on_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_o) |-> $past(ev_i));
   p_irq_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(afe_i && (!bkup_i || abe_i)));
   p_read_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && irq_o && !ev_i) |=> (!irq_o && flag_o));
   p_read_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !irq_o && !ev_i) |=> !flag_o);
   p_event_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
      ev_i |=> flag_o);
endmodule

// File: rtl/alm_matcher.sv
module alm_matcher
   import alm_pkg::*;
#(
   parameter int FW       = 8,
   parameter int PIPE_CMP = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic [FW-1:0] cur_sec_i,
   input  logic [FW-1:0] cur_min_i,
   input  logic [FW-1:0] cur_hr_i,
   input  logic [FW-1:0] cur_date_i,
   input  logic [FW-1:0] cur_mon_i,
   input  logic [FW-1:0] alm_sec_i,
   input  logic [FW-1:0] alm_min_i,
   input  logic [FW-1:0] alm_hr_i,
   input  logic [FW-1:0] alm_date_i,
   input  logic [FW-1:0] alm_mon_i,
   input  logic [4:0]    rpt_i,
   input  logic          afe_i,
   input  logic          abe_i,
   input  logic          bkup_i,
   input  logic          flags_rd_i,
   output logic          alarm_flag_o,
   output logic          irq_o
);
   if (FW < 8 || (FW % 4) != 0) begin : g_bad_fw
      $error("alm_matcher: FW must hold two BCD digits in whole nibbles");
   end
   if (PIPE_CMP != 0 && PIPE_CMP != 1) begin : g_bad_pipe
      $error("alm_matcher: PIPE_CMP must be 0 or 1");
   end

   logic [NF-1:0][FW-1:0] cur, alm;
   fmask_t mask;
   logic   ev;

   assign cur[F_SEC]  = cur_sec_i;
   assign cur[F_MIN]  = cur_min_i;
   assign cur[F_HR]   = cur_hr_i;
   assign cur[F_DATE] = cur_date_i;
   assign cur[F_MON]  = cur_mon_i;
   assign alm[F_SEC]  = alm_sec_i;
   assign alm[F_MIN]  = alm_min_i;
   assign alm[F_HR]   = alm_hr_i;
   assign alm[F_DATE] = alm_date_i;
   assign alm[F_MON]  = alm_mon_i;

   alm_mask_dec #(.RW(5)) u_dec (
      .code_i (rpt_i),
      .mask_o (mask)
   );

   alm_field_cmp #(.FW(FW), .PIPE_CMP(PIPE_CMP)) u_cmp (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_i),
      .cur_i  (cur),
      .alm_i  (alm),
      .mask_i (mask),
      .ev_o   (ev)
   );

   alm_irq_ctrl u_ctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev_i   (ev),
      .afe_i  (afe_i),
      .abe_i  (abe_i),
      .bkup_i (bkup_i),
      .rd_i   (flags_rd_i),
      .flag_o (alarm_flag_o),
      .irq_o  (irq_o)
   );
endmodule

// File: tb/tb_alm_matcher.sv
`timescale 1ns/1ps
module tb_alm_matcher;
   logic clk = 1'b0, rst_n = 1'b0;
   logic tick = 1'b0, frd = 1'b0, afe = 1'b0, abe = 1'b0, bkup = 1'b0;
   logic [4:0] rpt = 5'b11111;
   logic [7:0] cf [5];
   logic [7:0] af [5];
   logic flag, irq;
   int n_run = 0, n_fail = 0;
   logic m_flag = 1'b0, m_irq = 1'b0;

   always #2 clk = ~clk;

   alm_matcher #(.FW(8), .PIPE_CMP(0)) dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick),
      .cur_sec_i(cf[0]), .cur_min_i(cf[1]), .cur_hr_i(cf[2]),
      .cur_date_i(cf[3]), .cur_mon_i(cf[4]),
      .alm_sec_i(af[0]), .alm_min_i(af[1]), .alm_hr_i(af[2]),
      .alm_date_i(af[3]), .alm_mon_i(af[4]),
      .rpt_i(rpt), .afe_i(afe), .abe_i(abe), .bkup_i(bkup),
      .flags_rd_i(frd), .alarm_flag_o(flag), .irq_o(irq)
   );

   task automatic chk(input logic act, input logic exp, input string req, input string what);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
      end
   endtask

   function automatic logic model_hit(input logic [4:0] code);
      int n;
      case (code)
         5'b11110: n = 1;
         5'b11100: n = 2;
         5'b11000: n = 3;
         5'b10000: n = 4;
         5'b00000: n = 5;
         default:  n = 0;
      endcase
      for (int i = 0; i < n; i++) if (cf[i] != af[i]) return 1'b0;
      return 1'b1;
   endfunction

   function automatic logic [7:0] rnd_bcd();
      return {1'b0, 3'($urandom % 6), 4'($urandom % 10)};
   endfunction

   // alarm random; clock equal except fields whose bit is set in diff
   task automatic mk(input logic [4:0] diff);
      for (int i = 0; i < 5; i++) begin
         af[i] = rnd_bcd();
         cf[i] = diff[i] ? (af[i] ^ 8'h01) : af[i];
      end
   endtask

   task automatic step(input logic tk, input logic rd, input string req, input string what);
      logic ev, gate;
      @(negedge clk);
      tick = tk; frd = rd;
      ev   = tk && model_hit(rpt);
      gate = afe && (!bkup || abe);
      @(posedge clk); #1;
      if (ev) begin m_flag = 1'b1; m_irq = m_irq | gate; end
      else if (rd) begin if (m_irq) m_irq = 1'b0; else m_flag = 1'b0; end
      chk(flag, m_flag, req, {what, " flag"});
      chk(irq,  m_irq,  req, {what, " irq"});
      tick = 1'b0; frd = 1'b0;
   endtask

   task automatic clr(input string req);
      step(1'b0, 1'b1, req, "clear read 1");
      step(1'b0, 1'b1, req, "clear read 2");
   endtask

   initial begin
      #80000;
      n_fail++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [4:0] codes [6] = '{5'b11111, 5'b11110, 5'b11100, 5'b11000, 5'b10000, 5'b00000};
      string      tags  [6] = '{"R2", "R3", "R4", "R5", "R6", "R7"};
      logic [4:0] bad   [4] = '{5'b10101, 5'b01111, 5'b00001, 5'b11101};
      void'($urandom(32'h1234_5eed));
      mk(5'b00000);
      repeat (3) @(posedge clk);
      #1; rst_n = 1'b1;
      chk(flag, 1'b0, "R1", "reset flag");
      chk(irq,  1'b0, "R1", "reset irq");

      // R9: matching fields but no strobe
      rpt = 5'b00000; mk(5'b00000);
      step(1'b0, 1'b0, "R9", "match without tick");
      step(1'b0, 1'b0, "R9", "match without tick again");

      // R2..R7: each code against a mismatch in each single field
      for (int c = 0; c < 6; c++) begin
         rpt = codes[c];
         for (int d = 0; d < 5; d++) begin
            mk(5'(1 << d));
            step(1'b1, 1'b0, tags[c], $sformatf("code %b diff field %0d", codes[c], d));
            clr(tags[c]);
         end
         mk(5'b00000);
         step(1'b1, 1'b0, tags[c], "full match");
         clr(tags[c]);
      end

      // R8: illegal codes fire with every field different
      for (int b = 0; b < 4; b++) begin
         rpt = bad[b]; mk(5'b11111);
         step(1'b1, 1'b0, "R8", $sformatf("illegal code %b", bad[b]));
         clr("R8");
      end

      // R10: normal-mode enable
      rpt = 5'b11111; afe = 1'b0; bkup = 1'b0;
      step(1'b1, 1'b0, "R10", "afe off");
      clr("R10");
      afe = 1'b1;
      step(1'b1, 1'b0, "R10", "afe on");
      // R12: two-stage clear
      step(1'b0, 1'b1, "R12", "first read releases irq");
      step(1'b0, 1'b1, "R12", "second read clears flag");

      // R11: backup gating
      bkup = 1'b1; afe = 1'b1; abe = 1'b0;
      step(1'b1, 1'b0, "R11", "backup abe off");
      clr("R11");
      afe = 1'b0; abe = 1'b1;
      step(1'b1, 1'b0, "R11", "backup afe off");
      clr("R11");
      afe = 1'b1;
      step(1'b1, 1'b0, "R11", "backup both on");

      // R13: event and read together, irq pending
      step(1'b1, 1'b1, "R13", "event+read irq pending");
      clr("R13");
      // R13: event and read together, flag only
      afe = 1'b0; bkup = 1'b0;
      step(1'b1, 1'b0, "R13", "set flag only");
      step(1'b1, 1'b1, "R13", "event+read flag only");
      clr("R13");

      // random mix
      for (int k = 0; k < 400; k++) begin
         logic [4:0] pick [8] = '{5'b11111, 5'b11110, 5'b11100, 5'b11000,
                                  5'b10000, 5'b00000, 5'b01010, 5'b11011};
         rpt  = pick[$urandom % 8];
         afe  = 1'($urandom); abe = 1'($urandom); bkup = 1'($urandom);
         mk(($urandom % 3 == 0) ? 5'($urandom) : 5'(1 << ($urandom % 5)) & 5'($urandom));
         step(1'($urandom % 3 != 0), 1'($urandom % 3 == 0), "R13", $sformatf("random %0d", k));
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule